// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous on-chip requester and an external asynchronous static RAM of 128K bytes. Each request carries an address, a direction flag and, for a write, one data byte. The controller turns it into a timed pin sequence on the memory side: two chip selects of opposite polarity, an active-low write strobe, an active-low output strobe, a 17-bit address and a byte-wide data bus. It ends every transaction with a single-cycle done pulse. Read data is returned together with that pulse.

All memory timing is met by counting clocks. Each minimum in nanoseconds is a parameter. It is rounded up to whole clock periods, so the same block can be retargeted to another clock or speed grade without editing the control. The data bus is split into an output value, an output enable and an input value for the pad ring. The controller drives the bus only around the write strobe and never while the memory is asked to drive it.

With the default 5 ns clock the write strobe is held for 3 cycles after 1 setup cycle and is followed by 1 hold cycle. The output strobe of a read is held for 3 cycles.

Top module: `asram_ctrl`

## Requirements
- R1: While idle, and from reset onwards, `memCe1N`=1, `memCe2`=0, `memWeN`=1, `memOeN`=1, `memDoe`=0 and `reqReady`=1.
- R2: A write holds both chip selects active for 5 cycles. The write strobe is low for exactly 3 consecutive cycles, starting after 1 cycle of active select. `memOeN` stays 1 whenever `memWeN` is 0.
- R3: `memDoe` is 1 only while `memWeN` is 0 or in the one cycle after it rises. It is never 1 while `memOeN` is 0. During the whole write strobe it is 1, and `memDout` carries the request's write byte.
- R4: `memAddr` does not change while the chip selects stay active. The driven write byte does not change while `memDoe` stays 1.
- R5: A read holds both chip selects active with `memOeN`=0 and `memWeN`=1 for exactly 3 consecutive cycles, and `memDoe` stays 0.
- R6: `rspRdata` equals the byte that the memory presents on `memDin` during the last cycle of the read's output window. It is valid while `rspDone` is 1.
- R7: `rspDone` is a one-cycle pulse in the first cycle after the chip selects go inactive. It comes 6 cycles after the accepting edge for a write and 4 for a read.
- R8: A request is accepted only on an edge where `reqReady` is 1. `reqReady` is 0 while the chip selects are active and during the done cycle, and `reqValid` is ignored during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write byte |
| reqReady | output | 1 | Controller idle, request will be accepted |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W | Read byte, valid with rspDone |
| memAddr | output | ADDR_W | Memory address pins |
| memDout | output | DATA_W | Data value for the bus drivers |
| memDoe | output | 1 | Bus driver enable |
| memDin | input | DATA_W | Data value seen on the bus |
| memCe1N | output | 1 | Active-low chip select |
| memCe2 | output | 1 | Active-high chip select |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low output strobe |

## Verification
A wrong phase or a wrong counter in the sequencer shows at the strobe pins within the same transaction. The write or output window comes out too short or too long, or is misplaced against the chip selects. The done pulse is also shifted against the accepting edge, so the fault is caught before the next request is issued. A bad capture point or a lost write shows one transaction later, when the byte read back from the bench's memory model does not match the arithmetic pattern that the full address sweep wrote. Bus contention and drive outside the write window are checked on every cycle.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WSETUP,
    PH_WPULSE,
    PH_WHOLD,
    PH_RACCESS,
    PH_DONE
  } phase_e;

  // strobes from the sequencer to the datapath, all registered
  typedef struct packed {
    logic chipSel;
    logic writeEn;
    logic outEn;
    logic drive;
    logic capture;
    logic done;
  } strobe_t;

  function automatic int cyclesFor(int ns, int periodNs);
    return (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 3,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output logic    load,
  output strobe_t strb
);

  localparam int MAX_CYC = maxOf(maxOf(SETUP_CYC, WE_CYC), maxOf(HOLD_CYC, RD_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LAST    = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(RD_CYC - 1);

  phase_e           phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext;

  function automatic strobe_t decode(phase_e p, logic [CNT_W-1:0] c);
    strobe_t s;
    s         = '0;
    s.chipSel = (p == PH_WSETUP) || (p == PH_WPULSE) || (p == PH_WHOLD) || (p == PH_RACCESS);
    s.writeEn = (p == PH_WPULSE);
    s.outEn   = (p == PH_RACCESS);
    s.drive   = (p == PH_WPULSE) || (p == PH_WHOLD);
    s.capture = (p == PH_RACCESS) && (c == RD_LAST);
    s.done    = (p == PH_DONE);
    return s;
  endfunction

  always_comb begin
    phaseNext = phase;
    cntNext   = cnt + 1'b1;
    load      = 1'b0;
    case (phase)
      PH_IDLE: begin
        cntNext = '0;
        if (reqValid) begin
          load      = 1'b1;
          phaseNext = reqWrite ? PH_WSETUP : PH_RACCESS;
        end
      end
      PH_WSETUP:  if (cnt == SETUP_LAST) begin phaseNext = PH_WPULSE; cntNext = '0; end
      PH_WPULSE:  if (cnt == WE_LAST)    begin phaseNext = PH_WHOLD;  cntNext = '0; end
      PH_WHOLD:   if (cnt == HOLD_LAST)  begin phaseNext = PH_DONE;   cntNext = '0; end
      PH_RACCESS: if (cnt == RD_LAST)    begin phaseNext = PH_DONE;   cntNext = '0; end
      PH_DONE:    begin phaseNext = PH_IDLE; cntNext = '0; end
      default:    begin phaseNext = PH_IDLE; cntNext = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      strb  <= '0;
    end else begin
      phase <= phaseNext;
      cnt   <= cntNext;
      strb  <= decode(phaseNext, cntNext);
    end
  end

  assign reqReady = (phase == PH_IDLE);

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspDone
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.capture) rdataQ <= memDin;
    end
  end

  assign memAddr  = addrQ;
  assign memDout  = wdataQ;
  assign memDoe   = strb.drive;
  assign memCe1N  = ~strb.chipSel;
  assign memCe2   = strb.chipSel;
  assign memWeN   = ~strb.writeEn;
  assign memOeN   = ~strb.outEn;
  assign rspRdata = rdataQ;
  assign rspDone  = strb.done;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 5,
  parameter int T_WPULSE_NS = 12,
  parameter int T_DSETUP_NS = 8,
  parameter int T_CEEND_NS  = 12,
  parameter int T_ASETUP_NS = 12,
  parameter int T_WCYC_NS   = 15,
  parameter int T_RCYC_NS   = 15,
  parameter int T_OEDATA_NS = 7,
  parameter int SETUP_CYC  = 1,
  parameter int HOLD_CYC   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  input  logic [DATA_W-1:0] memDin,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN
);

  // write strobe covers pulse width, data setup and the select/address-to-end minima
  localparam int WE_CYC = maxOf(
      maxOf(cyclesFor(T_WPULSE_NS, CLK_NS), cyclesFor(T_DSETUP_NS, CLK_NS)),
      maxOf(cyclesFor(T_CEEND_NS, CLK_NS) - SETUP_CYC, cyclesFor(T_ASETUP_NS, CLK_NS) - SETUP_CYC));
  localparam int HOLD_EFF = maxOf(HOLD_CYC, cyclesFor(T_WCYC_NS, CLK_NS) - SETUP_CYC - WE_CYC);
  localparam int RD_CYC   = maxOf(cyclesFor(T_RCYC_NS, CLK_NS), cyclesFor(T_OEDATA_NS, CLK_NS));

  strobe_t strb;
  logic    load;

  asram_seq #(
    .SETUP_CYC(SETUP_CYC),
    .WE_CYC   (WE_CYC),
    .HOLD_CYC (HOLD_EFF),
    .RD_CYC   (RD_CYC)
  ) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .load    (load),
    .strb    (strb)
  );

  asram_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .load    (load),
    .strb    (strb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memDin  (memDin),
    .memAddr (memAddr),
    .memDout (memDout),
    .memDoe  (memDoe),
    .memCe1N (memCe1N),
    .memCe2  (memCe2),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .rspRdata(rspRdata),
    .rspDone (rspDone)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspDone,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDout,
  input logic              memDoe,
  input logic              memCe1N,
  input logic              memCe2,
  input logic              memWeN,
  input logic              memOeN
);

  a_r1_idle_inactive: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCe1N && !memCe2 && memWeN && memOeN && !memDoe));

  a_r2_write_strobes: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && !memCe1N && memCe2 && memDoe));

  a_r3_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDoe);

  a_r3_drive_window: assert property (@(posedge clk) disable iff (!rstN)
    memDoe |-> (!memWeN || $past(!memWeN)));

  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memCe1N && $past(!memCe1N)) |-> $stable(memAddr));

  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memDoe && $past(memDoe)) |-> $stable(memDout));

  a_r5_read_strobes: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memCe1N && memCe2));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (!memCe1N || rspDone) |-> !reqReady);

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .rspDone (rspDone),
  .memAddr (memAddr),
  .memDout (memDout),
  .memDoe  (memDoe),
  .memCe1N (memCe1N),
  .memCe2  (memCe2),
  .memWeN  (memWeN),
  .memOeN  (memOeN)
);

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqReady, rspDone;
  logic [DW-1:0] rspRdata;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memDout, memDin;
  logic          memDoe, memCe1N, memCe2, memWeN, memOeN;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_asram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspDone(rspDone), .rspRdata(rspRdata), .memAddr(memAddr),
    .memDout(memDout), .memDoe(memDoe), .memDin(memDin),
    .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // memory model: drives only when selected, output strobe low, write strobe high
  logic [DW-1:0] model [DEPTH];
  wire ceAct = !memCe1N && memCe2;
  assign memDin = (ceAct && !memOeN && memWeN) ? model[memAddr] : 8'hEE;

  int ceRun = 0, weRun = 0, oeRun = 0;
  bit sawWe = 0, cePrev = 0, wePrev = 0, doePrev = 0, donePrev = 0;
  logic [AW-1:0] addrPrev = '0, pendAddr = '0;
  logic [DW-1:0] doutPrev = '0, pendData = '0;

  always @(negedge clk) begin
    if (rstN) begin
      // per-cycle rules
      if (memDoe) check(!memWeN || wePrev, "R3 drive outside window", memDoe, 0);
      if (!memOeN) check(!memDoe, "R3 contention", memDoe, 0);
      if (!memWeN) check(memOeN, "R2 oe during write", memOeN, 1);
      if (ceAct && cePrev) check(memAddr == addrPrev, "R4 address moved", memAddr, addrPrev);
      if (memDoe && doePrev) check(memDout == doutPrev, "R4 data moved", memDout, doutPrev);
      if (rspDone) check(!donePrev, "R7 done longer than one cycle", 1, 0);
      if (ceAct || rspDone) check(!reqReady, "R8 ready while busy", reqReady, 0);
      if (ceAct != memCe2 || ceAct == memCe1N) check(0, "R1 selects disagree", memCe2, !memCe1N);

      // write strobe window
      if (!memWeN) begin
        if (weRun == 0) check(ceRun == 1, "R2 select setup before strobe", ceRun, 1);
        weRun++; sawWe = 1;
        check(memDoe, "R3 not driving during strobe", memDoe, 1);
        pendAddr = memAddr; pendData = memDout;
      end else if (weRun > 0) begin
        check(weRun == 3, "R2 write strobe length", weRun, 3);
        model[pendAddr] = pendData;
        weRun = 0;
      end

      // output strobe window
      if (!memOeN) oeRun++;
      else if (oeRun > 0) begin
        check(oeRun == 3, "R5 output strobe length", oeRun, 3);
        oeRun = 0;
      end

      // select window
      if (ceAct) ceRun++;
      else if (ceRun > 0) begin
        check(ceRun == (sawWe ? 5 : 3), "R2/R5 select window length", ceRun, sawWe ? 5 : 3);
        check(rspDone, "R7 done after select window", rspDone, 1);
        ceRun = 0; sawWe = 0;
      end
      if (!memOeN) check(memWeN && !memDoe, "R5 read strobes", memDoe, 0);
    end
    cePrev = ceAct; wePrev = !memWeN; doePrev = memDoe; donePrev = rspDone;
    addrPrev = memAddr; doutPrev = memDout;
  end

  function automatic logic [DW-1:0] pat1(int a);
    return DW'((a * 37 + 5) & 8'hFF);
  endfunction

  function automatic logic [DW-1:0] pat2(int a);
    return DW'(((a * 11) ^ 8'hC3) & 8'hFF);
  endfunction

  // issue one request starting at a negedge; optional stray request while busy
  task automatic txn(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, bit stray,
                     output logic [DW-1:0] rd);
    int lat;
    int wait_n = 0;
    while (!reqReady && wait_n < 50) begin @(negedge clk); wait_n++; end
    check(reqReady, "R8 ready before request", reqReady, 1);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 0;
    lat = 1;
    while (!rspDone && lat < 50) begin
      if (stray && lat < 4) begin
        reqValid = 1; reqWrite = 1; reqAddr = AW'(9); reqWdata = 8'h3C;
      end else reqValid = 0;
      @(negedge clk);
      lat++;
    end
    reqValid = 0;
    check(lat == (wr ? 6 : 4), "R7 done latency", lat, wr ? 6 : 4);
    rd = rspRdata;
    @(negedge clk);
    check(reqReady, "R8 ready after done", reqReady, 1);
  endtask

  initial begin
    logic [DW-1:0] rd;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(memCe1N && !memCe2 && memWeN && memOeN && !memDoe && !rspDone,
          "R1 outputs in reset", {memCe1N, memCe2, memWeN, memOeN, memDoe}, 5'b10110);
    rstN = 1;
    @(negedge clk);
    check(reqReady && memCe1N && !memCe2 && memWeN && memOeN && !memDoe,
          "R1 idle after reset", {reqReady, memCe1N, memCe2, memWeN, memOeN, memDoe}, 6'b110110);

    for (int a = 0; a < DEPTH; a++) txn(1, AW'(a), pat1(a), 0, rd);
    for (int a = 0; a < DEPTH; a++) begin
      txn(0, AW'(a), 8'h00, 0, rd);
      check(rd == pat1(a), "R6 readback pattern one", rd, pat1(a));
    end
    for (int a = DEPTH - 1; a >= 0; a--) txn(1, AW'(a), pat2(a), 0, rd);
    for (int a = 0; a < DEPTH; a++) begin
      txn(0, AW'(a), 8'h00, 0, rd);
      check(rd == pat2(a), "R6 readback pattern two", rd, pat2(a));
    end

    // stray request while busy must be ignored
    txn(1, AW'(2), 8'h11, 1, rd);
    txn(0, AW'(9), 8'h00, 0, rd);
    check(rd == pat2(9), "R8 stray write ignored", rd, pat2(9));
    txn(0, AW'(2), 8'h00, 1, rd);
    check(rd == 8'h11, "R6 read with stray request", rd, 8'h11);
    txn(0, AW'(9), 8'h00, 0, rd);
    check(rd == pat2(9), "R8 stray during read ignored", rd, pat2(9));
    check(reqReady && memCe1N && memWeN && memOeN && !memDoe, "R1 idle at end", reqReady, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule